// File: doc/BRIEF.md
# Register-File Pattern Tester

This block is a built-in self-test engine for a small register file or lookup table. When it accepts a start request it works through five data passes over the whole storage. In each pass it first writes every word and then reads every word back and compares it with the value written. The passes are all-zero, all-one, the two alternating-bit words, and finally a pass that stores each entry's own index as its data. Mismatches go into a saturating error counter. The first mismatch of a run is kept in a sticky record that holds the entry index, the word half and the pass number.

The storage under test connects through a synchronous write port and a read port. Read data arrives one clock after the read address. Two shapes are supported: 32 entries of one 32-bit word (the default), or 64 entries of two words each, where the words are addressed separately. When the last pass is complete the block gives a one-cycle done pulse, and the error count is then ready for a host reporter. After that the block either stops or, if the repeat input is high, starts the next round at once.

Top module: `rf_pattern_bist`

## Requirements
- R1: The first four passes write the same word to every address, in this order: pass 0 writes 0x00000000, pass 1 writes 0xFFFFFFFF, pass 2 writes 0xAAAAAAAA and pass 3 writes 0x55555555.
- R2: Pass 4, the last pass, writes each word with its entry index, zero-extended. In the two-word shape both words of an entry carry the same index. An address-aliasing fault that the constant passes cannot see is therefore counted.
- R3: Each pass first writes the addresses 0 up to the last address in ascending order, one per cycle. It then reads them in the same order, one per cycle. No write and read happen in the same cycle, and all reads of a pass follow all of its writes.
- R4: The read data is compared in the cycle after the read address was presented. Each word that differs from the value written in that pass adds one to the error count.
- R5: The error counter is ERR_W bits wide (16 by default). It never decreases except on an accepted start, and it holds at its all-ones value instead of wrapping.
- R6: An accepted start clears the error count and the first-fail record. In repeat mode the following rounds add to the count without clearing it.
- R7: done_o is high for exactly one cycle. That cycle comes 5*(2*W+1) clocks after the clock edge that accepted start, where W is the number of words. busy_o is high from the accepting edge until done_o, and it goes low after done_o when repeat_i is low.
- R8: A start_i request that arrives while busy_o is high has no effect. It clears nothing and does not lengthen the run.
- R9: If repeat_i is high in the done cycle, a new round starts at pass 0 in the next cycle and busy_o stays high. Otherwise the block goes idle.
- R10: fail_valid_o goes high on the first mismatch after a start. fail_index_o, fail_word_o and fail_pass_o (the pass number 0 to 4) then hold the entry index, the word half and the pass of that mismatch until the next accepted start.
- R11: With ENTRIES=64 and WORDS=2, the storage address is {entry, half}, with the half in bit 0, so 128 words are tested in each pass.
- R12: After reset the block is idle: busy_o, done_o, fail_valid_o, mem_we_o and mem_re_o are low and err_count_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| repeat_i | input | 1 | High: start another round after done |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle pulse when a round ends |
| err_count_o | output | ERR_W | Saturating mismatch count |
| fail_valid_o | output | 1 | A first-fail record has been captured |
| fail_index_o | output | IDX_W | Entry index of the first mismatch |
| fail_word_o | output | 1 | Word half of the first mismatch |
| fail_pass_o | output | 3 | Pass number of the first mismatch |
| mem_we_o | output | 1 | Storage write enable |
| mem_waddr_o | output | AW | Storage write address |
| mem_wdata_o | output | 32 | Storage write data |
| mem_re_o | output | 1 | Storage read enable |
| mem_raddr_o | output | AW | Storage read address |
| mem_rdata_i | input | 32 | Storage read data, valid one cycle after mem_re_o |

## Verification
The embedded assertions check the following on every cycle: the done pulse is a single cycle wide, write and read never overlap, addresses step by one within a burst, reads begin only after the last write of a pass, a start that arrives while busy cannot end the run, and the counter never decreases, never wraps and keeps the first-fail record stable. Other behaviours can be shown only by the bench's scenarios, because they depend on what the storage returns. These are the exact number of errors that each injected fault (stuck-at-one, stuck-at-zero, address aliasing, all bits inverted) produces, the contents of the first-fail record, the pattern and index values on the write port, the exact run length in both storage shapes, and saturation after several repeat rounds.

// File: rtl/rfpb_pkg.sv
`timescale 1ns/1ps
package rfpb_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_PASSES = 5;
    localparam int IDX_ARG_W  = 16;

    typedef enum logic [2:0] {
        PASS_ZERO   = 3'd0,
        PASS_ONES   = 3'd1,
        PASS_ALT_HI = 3'd2,
        PASS_ALT_LO = 3'd3,
        PASS_INDEX  = 3'd4
    } pass_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_DRAIN,
        ST_FINISH
    } seq_state_e;

    // Data word that a given pass stores at a given entry.
    function automatic logic [WORD_W-1:0] pattern_of(pass_e p, logic [IDX_ARG_W-1:0] idx);
        logic [WORD_W-1:0] w;
        case (p)
            PASS_ZERO:   w = '0;
            PASS_ONES:   w = '1;
            PASS_ALT_HI: w = {(WORD_W/2){2'b10}};
            PASS_ALT_LO: w = {(WORD_W/2){2'b01}};
            default:     w = WORD_W'(idx);
        endcase
        return w;
    endfunction

    function automatic logic is_final_pass(pass_e p);
        return p == PASS_INDEX;
    endfunction

endpackage

// File: rtl/rfpb_sequencer.sv
`timescale 1ns/1ps
module rfpb_sequencer
    import rfpb_pkg::*;
#(
    parameter int AW     = 5,
    parameter int WORDS  = 1,
    parameter int NWORDS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              repeat_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              clear_o,
    output pass_e             pass_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o
);

    localparam int            HALF_W    = (WORDS == 2) ? 1 : 0;
    localparam logic [AW-1:0] LAST_ADDR = AW'(NWORDS - 1);

    seq_state_e         state_q;
    pass_e              pass_q;
    logic [AW-1:0]      addr_q;
    logic [IDX_ARG_W-1:0] entry_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pass_q  <= PASS_ZERO;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_WRITE;
                        pass_q  <= PASS_ZERO;
                        addr_q  <= '0;
                    end
                end
                ST_WRITE: begin
                    if (addr_q == LAST_ADDR) begin
                        addr_q  <= '0;
                        state_q <= ST_READ;
                    end else begin
                        addr_q <= addr_q + AW'(1);
                    end
                end
                ST_READ: begin
                    if (addr_q == LAST_ADDR) begin
                        addr_q  <= '0;
                        state_q <= ST_DRAIN;
                    end else begin
                        addr_q <= addr_q + AW'(1);
                    end
                end
                ST_DRAIN: begin
                    if (is_final_pass(pass_q)) begin
                        state_q <= ST_FINISH;
                    end else begin
                        pass_q  <= pass_e'(pass_q + 3'd1);
                        state_q <= ST_WRITE;
                    end
                end
                ST_FINISH: begin
                    if (repeat_i) begin
                        state_q <= ST_WRITE;
                        pass_q  <= PASS_ZERO;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign entry_idx   = IDX_ARG_W'(addr_q >> HALF_W);
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_FINISH);
    assign clear_o     = (state_q == ST_IDLE) && start_i;
    assign pass_o      = pass_q;
    assign mem_we_o    = (state_q == ST_WRITE);
    assign mem_re_o    = (state_q == ST_READ);
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = pattern_of(pass_q, entry_idx);

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                            // R7
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !done_o) |=> busy_o);                     // R8
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_we_o && mem_re_o));                                       // R3
    AST_WRITE_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == AW'($past(mem_addr_o) + AW'(1))); // R3
    AST_READ_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (mem_re_o && $past(mem_re_o)) |-> mem_addr_o == AW'($past(mem_addr_o) + AW'(1))); // R3
    AST_READS_AFTER_WRITES: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_re_o) |-> ($past(mem_we_o) && $past(mem_addr_o) == LAST_ADDR)); // R3
    AST_REPEAT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (done_o && repeat_i) |=> (busy_o && mem_we_o && pass_o == PASS_ZERO)); // R9

endmodule

// File: rtl/rfpb_checker.sv
`timescale 1ns/1ps
module rfpb_checker
    import rfpb_pkg::*;
#(
    parameter int AW    = 5,
    parameter int WORDS = 1,
    parameter int IDX_W = 5,
    parameter int ERR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              rd_issue_i,
    input  logic [AW-1:0]     rd_addr_i,
    input  pass_e             pass_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [ERR_W-1:0]  err_cnt_o,
    output logic              fail_valid_o,
    output logic [IDX_W-1:0]  fail_idx_o,
    output logic              fail_half_o,
    output pass_e             fail_pass_o
);

    localparam int               HALF_W  = (WORDS == 2) ? 1 : 0;
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic              pend_q;
    logic [AW-1:0]     pend_addr_q;
    pass_e             pend_pass_q;
    logic [IDX_W-1:0]  pend_idx;
    logic              pend_half;
    logic [WORD_W-1:0] expect_word;
    logic              mismatch;

    logic [ERR_W-1:0]  cnt_q;
    logic              fv_q;
    logic [IDX_W-1:0]  fidx_q;
    logic              fhalf_q;
    pass_e             fpass_q;

    // Track the read in flight: its data arrives one cycle later.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_pass_q <= PASS_ZERO;
        end else begin
            pend_q      <= rd_issue_i;
            pend_addr_q <= rd_addr_i;
            pend_pass_q <= pass_i;
        end
    end

    assign pend_idx = IDX_W'(pend_addr_q >> HALF_W);

    generate
        if (WORDS == 2) begin : g_two_words
            assign pend_half = pend_addr_q[0];
        end else begin : g_one_word
            assign pend_half = 1'b0;
        end
    endgenerate

    assign expect_word = pattern_of(pend_pass_q, IDX_ARG_W'(pend_idx));
    assign mismatch    = pend_q && (rd_data_i != expect_word);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q   <= '0;
            fv_q    <= 1'b0;
            fidx_q  <= '0;
            fhalf_q <= 1'b0;
            fpass_q <= PASS_ZERO;
        end else if (mismatch) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + ERR_W'(1);
            end
            if (!fv_q) begin
                fv_q    <= 1'b1;
                fidx_q  <= pend_idx;
                fhalf_q <= pend_half;
                fpass_q <= pend_pass_q;
            end
        end
    end

    assign err_cnt_o    = cnt_q;
    assign fail_valid_o = fv_q;
    assign fail_idx_o   = fidx_q;
    assign fail_half_o  = fhalf_q;
    assign fail_pass_o  = fpass_q;

    AST_COUNT_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> cnt_q >= $past(cnt_q));                            // R5
    AST_COUNT_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !clear_i) |=> cnt_q == CNT_MAX);           // R5
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (cnt_q == '0 && !fv_q));                            // R6
    AST_FIRST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fv_q && !clear_i) |=> (fv_q && $stable(fidx_q) && $stable(fhalf_q) && $stable(fpass_q))); // R10
    AST_MISMATCH_SEEN: assert property (@(posedge clk) disable iff (rst)
        (mismatch && !clear_i) |=> fv_q);                               // R10

endmodule

// File: rtl/rf_pattern_bist.sv
`timescale 1ns/1ps
module rf_pattern_bist
    import rfpb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int WORDS   = 1,
    parameter int ERR_W   = 16,
    localparam int NWORDS = ENTRIES * WORDS,
    localparam int AW     = $clog2(NWORDS),
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              repeat_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ERR_W-1:0]  err_count_o,
    output logic              fail_valid_o,
    output logic [IDX_W-1:0]  fail_index_o,
    output logic              fail_word_o,
    output logic [2:0]        fail_pass_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_waddr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              mem_re_o,
    output logic [AW-1:0]     mem_raddr_o,
    input  logic [WORD_W-1:0] mem_rdata_i
);

    logic          seq_clear;
    pass_e         seq_pass;
    logic [AW-1:0] seq_addr;
    logic          seq_re;
    pass_e         chk_fail_pass;

    rfpb_sequencer #(
        .AW     (AW),
        .WORDS  (WORDS),
        .NWORDS (NWORDS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .repeat_i    (repeat_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .clear_o     (seq_clear),
        .pass_o      (seq_pass),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (seq_re),
        .mem_addr_o  (seq_addr),
        .mem_wdata_o (mem_wdata_o)
    );

    rfpb_checker #(
        .AW    (AW),
        .WORDS (WORDS),
        .IDX_W (IDX_W),
        .ERR_W (ERR_W)
    ) u_chk (
        .clk          (clk),
        .rst          (rst),
        .clear_i      (seq_clear),
        .rd_issue_i   (seq_re),
        .rd_addr_i    (seq_addr),
        .pass_i       (seq_pass),
        .rd_data_i    (mem_rdata_i),
        .err_cnt_o    (err_count_o),
        .fail_valid_o (fail_valid_o),
        .fail_idx_o   (fail_index_o),
        .fail_half_o  (fail_word_o),
        .fail_pass_o  (chk_fail_pass)
    );

    assign mem_waddr_o = seq_addr;
    assign mem_raddr_o = seq_addr;
    assign mem_re_o    = seq_re;
    assign fail_pass_o = chk_fail_pass;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mem_we_o && !mem_re_o && !done_o));               // R12

endmodule

// File: tb/rf_pattern_bist_test.sv
`timescale 1ns/1ps
module tb_mem #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata,
    input  logic [AW-1:0] s1_addr,
    input  logic [31:0]   s1_mask,
    input  logic [AW-1:0] s0_addr,
    input  logic [31:0]   s0_mask,
    input  logic          alias_en,
    input  logic [AW-1:0] alias_src,
    input  logic [AW-1:0] alias_dst,
    input  logic          invert_all
);
    logic [31:0] cells [2**AW];
    always @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
            if (alias_en && waddr == alias_src) cells[alias_dst] <= wdata;
        end
        if (re) begin
            rdata <= ((cells[raddr] | ((raddr == s1_addr) ? s1_mask : 32'h0))
                      & ~((raddr == s0_addr) ? s0_mask : 32'h0)) ^ {32{invert_all}};
        end
    end
endmodule

module rf_pattern_bist_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int p, int idx);
        case (p)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'hAAAA_AAAA;
            3: return 32'h5555_5555;
            default: return 32'(idx);
        endcase
    endfunction

    // ---------------- default instance: 32 x 1 ----------------
    logic        start = 1'b0, rep = 1'b0;
    logic        busy, done, fv, fword, we, re;
    logic [15:0] errc;
    logic [4:0]  fidx, waddr, raddr;
    logic [2:0]  fpass;
    logic [31:0] wdata, rdata;
    logic [4:0]  m_s1_addr = '0, m_s0_addr = '0, m_al_src = '0, m_al_dst = '0;
    logic [31:0] m_s1_mask = '0, m_s0_mask = '0;
    logic        m_al_en = 1'b0;

    rf_pattern_bist uut (
        .clk(clk), .rst(rst), .start_i(start), .repeat_i(rep),
        .busy_o(busy), .done_o(done), .err_count_o(errc),
        .fail_valid_o(fv), .fail_index_o(fidx), .fail_word_o(fword), .fail_pass_o(fpass),
        .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata),
        .mem_re_o(re), .mem_raddr_o(raddr), .mem_rdata_i(rdata)
    );
    tb_mem #(.AW(5)) mem0 (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .re(re), .raddr(raddr), .rdata(rdata),
        .s1_addr(m_s1_addr), .s1_mask(m_s1_mask), .s0_addr(m_s0_addr), .s0_mask(m_s0_mask),
        .alias_en(m_al_en), .alias_src(m_al_src), .alias_dst(m_al_dst), .invert_all(1'b0)
    );

    // ---------------- two-word instance: 64 x 2 ----------------
    logic        d_start = 1'b0;
    logic        d_busy, d_done, d_fv, d_fword, d_we, d_re;
    logic [15:0] d_errc;
    logic [5:0]  d_fidx;
    logic [6:0]  d_waddr, d_raddr;
    logic [2:0]  d_fpass;
    logic [31:0] d_wdata, d_rdata;

    rf_pattern_bist #(.ENTRIES(64), .WORDS(2)) uut_dual (
        .clk(clk), .rst(rst), .start_i(d_start), .repeat_i(1'b0),
        .busy_o(d_busy), .done_o(d_done), .err_count_o(d_errc),
        .fail_valid_o(d_fv), .fail_index_o(d_fidx), .fail_word_o(d_fword), .fail_pass_o(d_fpass),
        .mem_we_o(d_we), .mem_waddr_o(d_waddr), .mem_wdata_o(d_wdata),
        .mem_re_o(d_re), .mem_raddr_o(d_raddr), .mem_rdata_i(d_rdata)
    );
    tb_mem #(.AW(7)) mem1 (
        .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata), .re(d_re), .raddr(d_raddr), .rdata(d_rdata),
        .s1_addr(7'd21), .s1_mask(32'h1), .s0_addr(7'd0), .s0_mask(32'h0),
        .alias_en(1'b0), .alias_src(7'd0), .alias_dst(7'd0), .invert_all(1'b0)
    );

    // ---------------- narrow-counter instance ----------------
    logic        s_start = 1'b0, s_rep = 1'b0;
    logic        s_busy, s_done, s_fv, s_fword, s_we, s_re;
    logic [7:0]  s_errc;
    logic [4:0]  s_fidx, s_waddr, s_raddr;
    logic [2:0]  s_fpass;
    logic [31:0] s_wdata, s_rdata;

    rf_pattern_bist #(.ERR_W(8)) uut_sat (
        .clk(clk), .rst(rst), .start_i(s_start), .repeat_i(s_rep),
        .busy_o(s_busy), .done_o(s_done), .err_count_o(s_errc),
        .fail_valid_o(s_fv), .fail_index_o(s_fidx), .fail_word_o(s_fword), .fail_pass_o(s_fpass),
        .mem_we_o(s_we), .mem_waddr_o(s_waddr), .mem_wdata_o(s_wdata),
        .mem_re_o(s_re), .mem_raddr_o(s_raddr), .mem_rdata_i(s_rdata)
    );
    tb_mem #(.AW(5)) mem2 (
        .clk(clk), .we(s_we), .waddr(s_waddr), .wdata(s_wdata), .re(s_re), .raddr(s_raddr), .rdata(s_rdata),
        .s1_addr(5'd0), .s1_mask(32'h0), .s0_addr(5'd0), .s0_mask(32'h0),
        .alias_en(1'b0), .alias_src(5'd0), .alias_dst(5'd0), .invert_all(1'b1)
    );

    // ---------------- port-stream monitors ----------------
    int wr_k, rd_k, bad_pat, bad_idx, bad_ord;
    always @(negedge clk) begin
        if (!rst) begin
            if (we && re) bad_ord++;
            if (we) begin
                if (waddr != 5'(wr_k % 32) || rd_k != (wr_k / 32) * 32) bad_ord++;
                if ((wr_k / 32) % 5 == 4) begin
                    if (wdata != exp_word(4, wr_k % 32)) bad_idx++;
                end else if (wdata != exp_word((wr_k / 32) % 5, 0)) bad_pat++;
                wr_k++;
            end
            if (re) begin
                if (raddr != 5'(rd_k % 32) || wr_k != (rd_k / 32 + 1) * 32) bad_ord++;
                rd_k++;
            end
        end
    end

    int d_wr_k = 0, d_bad = 0;
    always @(negedge clk) begin
        if (!rst && d_we) begin
            if (d_waddr != 7'(d_wr_k % 128)) d_bad++;
            if (d_wdata != exp_word((d_wr_k / 128) % 5, (d_wr_k % 128) / 2)) d_bad++;
            d_wr_k++;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int    cnt;
        bit    fv;
        int    fi;
        int    fw;
        int    fp;
        string tag;
    } exp_t;
    exp_t sbq[$];

    task automatic expect_round(int c, bit v, int fi, int fw, int fp, string tag);
        exp_t e;
        e.cnt = c; e.fv = v; e.fi = fi; e.fw = fw; e.fp = fp; e.tag = tag;
        sbq.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                chk("R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, "error count", errc, e.cnt);
                chk("R10", "fail valid", fv, e.fv);
                if (e.fv) begin
                    chk("R10", "fail index", fidx, e.fi);
                    chk("R10", "fail word", fword, e.fw);
                    chk("R10", "fail pass", fpass, e.fp);
                end
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic clear_faults();
        m_s1_mask = '0; m_s0_mask = '0; m_al_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        wr_k = 0; rd_k = 0; bad_pat = 0; bad_idx = 0; bad_ord = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int cyc);
        while (!done) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic check_streams(string tag);
        chk("R1", {tag, " constant-pass write data"}, bad_pat, 0);
        chk("R2", {tag, " index-pass write data"}, bad_idx, 0);
        chk("R3", {tag, " address order"}, bad_ord, 0);
    endtask

    task automatic run_single(string tag);
        int cyc;
        cyc = 0;
        pulse_start();
        chk("R7", {tag, " busy after start"}, busy, 1);
        wait_done(cyc);
        chk("R7", {tag, " run length"}, cyc, 325);
        @(negedge clk);
        chk("R7", {tag, " done one cycle"}, done, 0);
        chk("R7", {tag, " idle after done"}, busy, 0);
        check_streams(tag);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int cyc;
        wr_k = 0; rd_k = 0; bad_pat = 0; bad_idx = 0; bad_ord = 0;
        repeat (4) @(negedge clk);
        chk("R12", "busy at reset", busy, 0);
        chk("R12", "done at reset", done, 0);
        chk("R12", "count at reset", errc, 0);
        chk("R12", "fail valid at reset", fv, 0);
        chk("R12", "write enable at reset", we, 0);
        chk("R12", "read enable at reset", re, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R4: stuck-at-1 bit 0 at entry 5 -> passes 0 and 2 fail
        m_s1_addr = 5'd5; m_s1_mask = 32'h1;
        expect_round(2, 1, 5, 0, 0, "R4");
        run_single("stuck1");

        // R6: clean storage after a faulty run -> count and record cleared
        clear_faults();
        expect_round(0, 0, 0, 0, 0, "R6");
        run_single("clean");

        // R4: stuck-at-0 bit 2 at entry 6 -> passes 1, 3 and 4 fail
        m_s0_addr = 5'd6; m_s0_mask = 32'h4;
        expect_round(3, 1, 6, 0, 1, "R4");
        run_single("stuck0");
        clear_faults();

        // R2: writes to entry 9 also land on entry 1 -> only the index pass sees it
        m_al_en = 1'b1; m_al_src = 5'd9; m_al_dst = 5'd1;
        expect_round(1, 1, 1, 0, 4, "R2");
        run_single("alias");
        clear_faults();

        // R8: start request in the middle of a run is ignored
        m_s0_addr = 5'd7; m_s0_mask = 32'h8000_0000;
        expect_round(2, 1, 7, 0, 1, "R8");
        cyc = 0;
        pulse_start();
        repeat (200) begin @(negedge clk); cyc++; end
        start = 1'b1;
        @(negedge clk); cyc++;
        start = 1'b0;
        chk("R8", "busy during run", busy, 1);
        wait_done(cyc);
        chk("R8", "run length with late start", cyc, 325);
        @(negedge clk);
        check_streams("late-start");

        // R9 / R6: repeat mode, count accumulates over two rounds
        expect_round(2, 1, 7, 0, 1, "R9");
        expect_round(4, 1, 7, 0, 1, "R6");
        rep = 1'b1;
        cyc = 0;
        pulse_start();
        wait_done(cyc);
        chk("R9", "first round length", cyc, 325);
        @(negedge clk);
        rep = 1'b0;
        chk("R9", "busy after repeat", busy, 1);
        chk("R9", "writing pass 0 again", we, 1);
        cyc = 0;
        wait_done(cyc);
        chk("R9", "second round length", cyc, 325);
        @(negedge clk);
        chk("R9", "idle after last round", busy, 0);
        check_streams("repeat");
        clear_faults();

        // R11: two-word shape, stuck-at-1 bit 0 at address {10,1}
        @(negedge clk);
        d_start = 1'b1;
        @(negedge clk);
        d_start = 1'b0;
        cyc = 0;
        while (!d_done) begin @(negedge clk); cyc++; end
        chk("R11", "two-word run length", cyc, 1285);
        chk("R11", "two-word error count", d_errc, 3);
        chk("R11", "two-word fail valid", d_fv, 1);
        chk("R11", "two-word fail index", d_fidx, 10);
        chk("R11", "two-word fail half", d_fword, 1);
        chk("R11", "two-word fail pass", d_fpass, 0);
        chk("R11", "two-word write stream", d_bad, 0);
        chk("R11", "two-word writes seen", d_wr_k, 640);

        // R5: every read wrong, 160 per round, 8-bit counter saturates
        s_rep = 1'b1;
        @(negedge clk);
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        while (!s_done) @(negedge clk);
        chk("R5", "count after one round", s_errc, 160);
        @(negedge clk);
        s_rep = 1'b0;
        while (!s_done) @(negedge clk);
        chk("R5", "count saturated", s_errc, 255);
        chk("R10", "saturating run fail pass", s_fpass, 0);
        chk("R10", "saturating run fail index", s_fidx, 0);
        @(negedge clk);
        chk("R5", "count holds after run", s_errc, 255);

        chk("R7", "scoreboard drained", sbq.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule